// File: doc/BRIEF.md
# Stack Frame Link/Unlink Engine

This block builds and tears down procedure stack frames for a processor with eight 32-bit address registers, the highest of which serves as the stack pointer. It keeps that address register file itself. A link command saves the chosen register on the stack and makes it the new frame pointer. It then moves the stack pointer by a signed displacement to reserve local storage. An unlink command reverses this: it drops the stack back to the frame pointer and restores the saved value from memory.

The displacement is supplied already fetched, either as a 16-bit value that is sign-extended or as a full 32-bit value. Each command makes exactly one 32-bit memory access through a request/acknowledge port. The surrounding core reads the registers through a combinational read port and loads them through a write port. When a command finishes, the block reports its nominal cycle cost.

Top module: `frame_link_engine`

## Requirements
- R1: A link command issues exactly one memory access. It is a write (`mem_we`=1) of the selected register's value as it was before the command, at address SP-4, where SP is register 7 at the moment the command is accepted.
- R2: When the link write is acknowledged, the selected register becomes SP-4, and then register 7 becomes SP-4 plus the displacement. The addition wraps modulo 2^32. When register 7 itself is selected, the two steps run in the same order, so register 7 ends at SP-4+displacement.
- R3: With `long_disp`=0 the displacement is `disp[15:0]` sign-extended and `disp[31:16]` has no effect. With `long_disp`=1 all 32 bits of `disp` are used.
- R4: An unlink command copies the selected register into register 7 when it is accepted. It then issues one memory read (`mem_we`=0) at that address. On acknowledge, register 7 becomes that address plus 4, and then the selected register takes the read data. When register 7 is selected, it therefore ends holding the read data.
- R5: `mem_req` stays high until `mem_ack`. While it waits, `mem_addr`, `mem_we` and `mem_wdata` do not change.
- R6: `busy` rises in the cycle after a start is accepted. With an acknowledge latency of L cycles after the request is seen, `busy` stays high for L+2 cycles and falls in the cycle after `mem_ack`. A `start` while `busy` is high is ignored.
- R7: `done` pulses for one cycle after the acknowledge. From then on, `cost` reads 16 for a link (either displacement form) and 12 for an unlink.
- R8: A register write (`ar_wr_en`) takes effect at the next clock edge only while the block is idle and no start is accepted in that cycle. Otherwise it has no effect.
- R9: After reset, all eight registers read zero, and `busy`, `mem_req`, `done` and `cost` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken when idle |
| unlink | input | 1 | 0 = link, 1 = unlink |
| long_disp | input | 1 | Link displacement form: 0 = 16-bit sign-extended, 1 = 32-bit |
| reg_sel | input | 3 | Selected address register |
| disp | input | 32 | Displacement |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| cost | output | 8 | Cycle cost of the last command |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the 32-bit access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| ar_wr_en | input | 1 | Register write enable |
| ar_wr_sel | input | 3 | Register write index |
| ar_wr_data | input | 32 | Register write data |
| ar_rd_sel | input | 3 | Register read index |
| ar_rd_data | output | 32 | Register read data (combinational) |

## Verification
The assertions assume that `mem_ack` comes only while `mem_req` is high, and at most once per request. They also assume `mem_rdata` is valid in the acknowledge cycle. The bench's memory model answers only an outstanding request and only once, after a latency that it varies between commands. That model keeps its own word store, so every pushed and popped value is predicted arithmetically. The sweep covers every register index with short positive, short negative (upper bits filled with junk) and long displacements. During each command it also injects a stray start and a stray register write.

// File: rtl/frame_link_engine.sv
module frame_link_engine #(
  parameter int DW        = 32,
  parameter int NREG      = 8,
  parameter int SHORT_W   = 16,
  parameter int CW        = 8,
  parameter int LINK_COST = 16,
  parameter int UNLK_COST = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      unlink,
  input  logic                      long_disp,
  input  logic [$clog2(NREG)-1:0]   reg_sel,
  input  logic [DW-1:0]             disp,
  output logic                      busy,
  output logic                      done,
  output logic [CW-1:0]             cost,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [DW-1:0]             mem_addr,
  output logic [DW-1:0]             mem_wdata,
  input  logic                      mem_ack,
  input  logic [DW-1:0]             mem_rdata,
  input  logic                      ar_wr_en,
  input  logic [$clog2(NREG)-1:0]   ar_wr_sel,
  input  logic [DW-1:0]             ar_wr_data,
  input  logic [$clog2(NREG)-1:0]   ar_rd_sel,
  output logic [DW-1:0]             ar_rd_data
);
  localparam int RW = $clog2(NREG);
  localparam int SP = NREG - 1;
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  logic [DW-1:0] ar [NREG];
  logic          busy_q, unl_q, done_q;
  logic [RW-1:0] sel_q;
  logic [DW-1:0] disp_q, addr_q, wdata_q;
  logic [CW-1:0] cost_q;

  wire           accept   = start && !busy_q;
  wire [DW-1:0]  disp_ext = long_disp ? disp : {{(DW-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) ar[i] <= '0;
      busy_q  <= 1'b0;
      unl_q   <= 1'b0;
      done_q  <= 1'b0;
      sel_q   <= '0;
      disp_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      cost_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        unl_q  <= unlink;
        sel_q  <= reg_sel;
        disp_q <= disp_ext;
        if (unlink) begin
          ar[SP]  <= ar[reg_sel];
          addr_q  <= ar[reg_sel];
          wdata_q <= '0;
        end else begin
          addr_q  <= ar[SP] - STEP;
          wdata_q <= ar[reg_sel];
        end
      end else if (busy_q && mem_ack) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        cost_q <= unl_q ? CW'(UNLK_COST) : CW'(LINK_COST);
        if (unl_q) begin
          ar[SP]    <= addr_q + STEP;
          ar[sel_q] <= mem_rdata;
        end else begin
          ar[sel_q] <= addr_q;
          ar[SP]    <= addr_q + disp_q;
        end
      end else if (!busy_q && ar_wr_en) begin
        ar[ar_wr_sel] <= ar_wr_data;
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign cost       = cost_q;
  assign mem_req    = busy_q;
  assign mem_we     = !unl_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
  assign ar_rd_data = ar[ar_rd_sel];

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  a_r1_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && mem_we |-> mem_addr == $past(ar[SP]) - STEP);
  a_r4_pop_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !mem_we |-> mem_addr == ar[SP]);
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_ack |=> busy && $stable(sel_q));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_ack |=> done && !busy);
  a_r2_sp_adjust: assert property (@(posedge clk) disable iff (!rst_n)
    done && mem_we |-> ar[SP] == $past(mem_addr) + disp_q);
endmodule

// File: tb/frame_link_engine_tb_top.sv
`timescale 1ns/1ps
module frame_link_engine_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start, unlink, long_disp, ar_wr_en, mem_ack;
  logic [2:0]  reg_sel, ar_wr_sel, ar_rd_sel;
  logic [31:0] disp, ar_wr_data, mem_rdata;
  logic        busy, done, mem_req, mem_we;
  logic [7:0]  cost;
  logic [31:0] mem_addr, mem_wdata, ar_rd_data;

  frame_link_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .unlink(unlink), .long_disp(long_disp),
    .reg_sel(reg_sel), .disp(disp), .busy(busy), .done(done), .cost(cost),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ar_wr_en(ar_wr_en), .ar_wr_sel(ar_wr_sel),
    .ar_wr_data(ar_wr_data), .ar_rd_sel(ar_rd_sel), .ar_rd_data(ar_rd_data));

  logic [31:0] mem [64];
  int          lat, lcnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 32'hC0DE_0000 + 32'(i * 16'h0101);
      mem_ack <= 1'b0; mem_rdata <= '0; lcnt <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (lcnt >= lat) begin
          mem_ack <= 1'b1; lcnt <= 0;
          if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
          else mem_rdata <= mem[mem_addr[7:2]];
        end else lcnt <= lcnt + 1;
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  logic [31:0] expr [8];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic wr_reg(int i, logic [31:0] v);
    @(negedge clk); ar_wr_en = 1; ar_wr_sel = 3'(i); ar_wr_data = v;
    @(negedge clk); ar_wr_en = 0;
    expr[i] = v;
  endtask

  task automatic check_regs(string req);
    for (int i = 0; i < 8; i++) begin
      ar_rd_sel = 3'(i); #0.1;
      chk(req, ar_rd_data, expr[i]);
    end
  endtask

  task automatic do_cmd(bit unl, bit lng, int sel, logic [31:0] d, int l);
    logic [31:0] dext, a, pushed;
    int bcnt;
    lat = l;
    dext = lng ? d : {{16{d[15]}}, d[15:0]};
    if (!unl) begin
      a = expr[7] - 4; pushed = expr[sel];
    end else begin
      a = expr[sel];
      pushed = mem[a[7:2]];
    end
    @(negedge clk);
    start = 1; unlink = unl; long_disp = lng; reg_sel = 3'(sel); disp = d;
    @(negedge clk);
    start = 0;
    chk("R6 busy rises", {31'b0, busy}, 1);
    chk("R5 direction", {31'b0, mem_we}, {31'b0, !unl});
    chk(unl ? "R4 pop address" : "R1 push address", mem_addr, a);
    if (!unl) chk("R1 push data", mem_wdata, pushed);
    start = 1; unlink = !unl; reg_sel = 3'(7 - sel); disp = 32'h0000_4444;
    ar_wr_en = 1; ar_wr_sel = 3'(sel); ar_wr_data = 32'hDEAD_BEEF;
    bcnt = 1;
    for (int k = 0; k < 50 && busy; k++) begin
      @(negedge clk);
      start = 0; ar_wr_en = 0;
      if (busy) bcnt++;
    end
    chk("R6 busy length", 32'(bcnt), 32'(l + 2));
    chk("R7 done pulse", {31'b0, done}, 1);
    chk("R7 cost", {24'b0, cost}, unl ? 32'd12 : 32'd16);
    if (!unl) begin
      chk("R1 memory written", mem[a[7:2]], pushed);
      expr[sel] = a;
      expr[7] = a + dext;
    end else begin
      expr[7] = a + 4;
      expr[sel] = pushed;
    end
    @(negedge clk);
    chk("R7 done single", {31'b0, done}, 0);
    check_regs(unl ? "R4 unlink regs" : (lng ? "R3 R2 long link regs" : "R3 R2 short link regs"));
  endtask

  initial begin
    rst_n = 0; start = 0; unlink = 0; long_disp = 0; reg_sel = 0; disp = 0;
    ar_wr_en = 0; ar_wr_sel = 0; ar_wr_data = 0; ar_rd_sel = 0; lat = 0;
    for (int i = 0; i < 8; i++) expr[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_regs("R9 reset regs");
    chk("R9 reset busy", {31'b0, busy}, 0);
    chk("R9 reset req", {31'b0, mem_req}, 0);
    chk("R9 reset done", {31'b0, done}, 0);
    chk("R9 reset cost", {24'b0, cost}, 0);

    @(negedge clk); ar_wr_en = 1; ar_wr_sel = 3; ar_wr_data = 32'h1234_5678; start = 1; unlink = 1; reg_sel = 0;
    @(negedge clk); ar_wr_en = 0; start = 0;
    for (int k = 0; k < 20 && !done; k++) @(negedge clk);
    expr[7] = 32'h4; expr[0] = mem[0];
    @(negedge clk);
    check_regs("R8 write lost to start");

    for (int sel = 0; sel < 8; sel++) begin
      for (int f = 0; f < 3; f++) begin
        for (int i = 0; i < 7; i++) wr_reg(i, 32'h1000_0000 + 32'(i * 32'h0011_0101) + 32'(sel * 16 + f));
        wr_reg(7, 32'h0000_0080 + 32'(sel * 8));
        check_regs("R8 idle write");
        case (f)
          0: do_cmd(0, 0, sel, 32'hABCD_0010, (sel + f) % 3);
          1: do_cmd(0, 0, sel, 32'h5A5A_FFE8, (sel + f) % 3);
          default: do_cmd(0, 1, sel, 32'h0001_0010, (sel + f) % 3);
        endcase
        do_cmd(1, 0, sel, 32'h0, (sel + f + 1) % 3);
      end
    end
    wr_reg(7, 32'h0000_0002);
    do_cmd(0, 1, 2, 32'hFFFF_FFF0, 1);
    summary();
  end
endmodule